// File: doc/BRIEF.md
# Character Cell Pixel Serializer

This block turns a line of text-mode cells into a serial pixel stream at one pixel per clock. Every cell is nine pixels wide. For each cell the block reads a 16-bit word (character code plus attribute byte) from an external display RAM through a synchronous read port. It then forms a glyph row address from font number, character code and scan row. It accepts the returned 8-bit glyph row together with an optional ninth-column bit from a second, one-bit-wide glyph store that shares the same address. Finally it shifts out nine pixels, each coloured with a 4-bit RGBI foreground or background value.

The ninth column has three sources. It can be blank, it can repeat the last glyph bit so that box-drawing shapes join up across cells, or it can come from the separate ninth-column store. The attribute byte is read in one of two ways. In colour mode its two nibbles are the foreground and background colours. In font mode its low nibble picks one of sixteen fonts for that character, and the background colour comes from a fixed input. All 256 character codes select glyphs. The block fetches the next cell while the current one is being shown, so consecutive cells follow each other with no idle pixel.

Top module: `char_cell_serializer`

## Requirements
- R1: After `line_start` is sampled at clock edge E, pixel j (0..8) of cell n is on `rgbi` in the cycle that follows edge E+9+9n+j. Cells follow each other with no gap. Pixels 0..7 are glyph bits 7 down to 0, so the most significant bit is the leftmost pixel.
- R2: The cell word read for cell n is taken from `dram_addr` = n, with the character in bits [7:0] and the attribute in bits [15:8]. The glyph address is {font[3:0], char[7:0], row[3:0]}. All eight character bits are used.
- R3: When `ext9` is low and `gfx` is low, the ninth pixel is off and shows the background colour.
- R4: When `ext9` is low and `gfx` is high, the ninth pixel equals glyph bit 0.
- R5: When `ext9` is high, the ninth pixel is the `glyph_ninth` bit returned for the same glyph address, whatever the value of `gfx`.
- R6: In colour mode (`font_mode` low), a lit pixel shows attribute bits [7:4] and an unlit pixel shows attribute bits [3:0]. The font field of the glyph address is zero.
- R7: In font mode (`font_mode` high), attribute bits [3:0] form the font field of the glyph address. Unlit pixels show `fixed_bg`, and lit pixels show attribute bits [7:4].
- R8: While `blank` is high, `rgbi` is 0. The pixel sequence is not disturbed.
- R9: After reset, and after each `line_start` until the first cell is loaded, `pix_valid` is low and `rgbi` is 0. `pix_valid` rises only when a cell is loaded and stays high until the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Restart at cell 0 of a new scan line |
| row | input | ROW_W | Scan row within the character, held for the line |
| font_mode | input | 1 | 1: attribute low nibble selects font |
| fixed_bg | input | 4 | Background colour used in font mode |
| gfx | input | 1 | Ninth column repeats glyph bit 0 |
| ext9 | input | 1 | Ninth column from separate store |
| blank | input | 1 | Force output colour to zero |
| dram_addr | output | COL_W | Cell index read from display RAM |
| dram_data | input | 16 | {attribute, character}, one cycle after address |
| glyph_addr | output | 16 | {font, character, row} |
| glyph_data | input | 8 | Glyph row, one cycle after address |
| glyph_ninth | input | 1 | Ninth-column bit, one cycle after address |
| rgbi | output | 4 | Pixel colour |
| pix_valid | output | 1 | A loaded cell is being shown |

## Verification
The bench builds the block with 16 cells per line and a 4-bit row. Sixteen lines per configuration then place all 256 character codes on screen, and the run covers all eight combinations of `ext9`, `gfx` and `font_mode`. With these settings every one of the 16 font numbers and every one of the 16 scan rows reaches the glyph address. Every pixel of every cell is compared against glyph and colour values that the bench computes arithmetically. The sweep also blanks one cell on odd lines and checks the idle window at the start of each line.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int CELL_PX = 9;
  localparam int GLY_W   = 8;
  localparam int CHAR_W  = 8;
  localparam int FONT_W  = 4;
  localparam int CLR_W   = 4;
  localparam int WORD_W  = CHAR_W + 8;

  typedef struct packed {
    logic [GLY_W-1:0] gly;
    logic             nin;
    logic [CLR_W-1:0] fg;
    logic [CLR_W-1:0] bg;
  } cell_t;

  // source of the ninth column
  function automatic logic ninth_f(input logic ext, input logic g,
                                   input logic [GLY_W-1:0] gly, input logic nin);
    if (ext)    return nin;
    else if (g) return gly[0];
    else        return 1'b0;
  endfunction

  function automatic logic [CLR_W-1:0] paint_f(input logic on,
                                               input logic [CLR_W-1:0] fg,
                                               input logic [CLR_W-1:0] bg);
    return on ? fg : bg;
  endfunction
endpackage

// File: rtl/ccs_timing.sv
module ccs_timing #(
  parameter int NCOLS = 80,
  localparam int COL_W = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  output logic [COL_W-1:0] col,
  output logic             cap_code,
  output logic             cap_glyph,
  output logic             load_ev
);
  import ccs_pkg::*;
  localparam int PH_W = $clog2(CELL_PX);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_PX - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NCOLS - 1);

  logic [PH_W-1:0] ph;

  assign cap_code  = (ph == PH_W'(1)) && !line_start;
  assign cap_glyph = (ph == PH_W'(3)) && !line_start;
  assign load_ev   = (ph == PH_LAST) && !line_start;

  always_ff @(posedge clk) begin
    if (!rst_n || line_start) begin
      ph  <= '0;
      col <= '0;
    end else if (ph == PH_LAST) begin
      ph  <= '0;
      col <= (col == COL_LAST) ? '0 : col + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  AST_CELL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (ph == '0)); // R1
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (col == (($past(col) == COL_LAST) ? '0 : $past(col) + 1'b1))); // R2
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !line_start) |=> $stable(col)); // R2
endmodule

// File: rtl/ccs_fetch.sv
module ccs_fetch #(
  parameter int ROW_W = 4,
  localparam int GADDR_W = ccs_pkg::FONT_W + ccs_pkg::CHAR_W + ROW_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_start,
  input  logic                      cap_code,
  input  logic                      cap_glyph,
  input  logic                      load_ev,
  input  logic [ccs_pkg::WORD_W-1:0] dram_data,
  input  logic                      font_mode,
  input  logic [3:0]                fixed_bg,
  input  logic [ROW_W-1:0]          row,
  output logic [GADDR_W-1:0]        glyph_addr,
  input  logic [ccs_pkg::GLY_W-1:0] glyph_data,
  input  logic                      glyph_ninth,
  output ccs_pkg::cell_t            hold,
  output logic                      hold_full
);
  import ccs_pkg::*;

  logic [CHAR_W-1:0] ch_r;
  logic [7:0]        at_r;
  logic              fm_r;
  logic [FONT_W-1:0] font_sel;

  assign font_sel   = fm_r ? at_r[FONT_W-1:0] : '0;
  assign glyph_addr = {font_sel, ch_r, row};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_r <= '0;
      at_r <= '0;
      fm_r <= 1'b0;
    end else if (cap_code) begin
      ch_r <= dram_data[CHAR_W-1:0];
      at_r <= dram_data[WORD_W-1:CHAR_W];
      fm_r <= font_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (cap_glyph) begin
      hold.gly <= glyph_data;
      hold.nin <= glyph_ninth;
      hold.fg  <= at_r[7:4];
      hold.bg  <= fm_r ? fixed_bg : at_r[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || line_start) hold_full <= 1'b0;
    else if (cap_glyph)       hold_full <= 1'b1;
    else if (load_ev)         hold_full <= 1'b0;
  end

  AST_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |-> hold_full); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !cap_glyph) |=> $stable(hold)); // R1
endmodule

// File: rtl/ccs_shifter.sv
module ccs_shifter (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_start,
  input  logic           load_ev,
  input  ccs_pkg::cell_t hold,
  input  logic           ext9,
  input  logic           gfx,
  input  logic           blank,
  output logic [3:0]     rgbi,
  output logic           pix_valid
);
  import ccs_pkg::*;

  logic [CELL_PX-1:0] sh;
  logic [CLR_W-1:0]   fg_r, bg_r;
  logic               on_px;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      fg_r <= '0;
      bg_r <= '0;
    end else if (load_ev) begin
      sh   <= {hold.gly, ninth_f(ext9, gfx, hold.gly, hold.nin)};
      fg_r <= hold.fg;
      bg_r <= hold.bg;
    end else begin
      sh <= {sh[CELL_PX-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || line_start) pix_valid <= 1'b0;
    else if (load_ev)         pix_valid <= 1'b1;
  end

  assign on_px = sh[CELL_PX-1];
  assign rgbi  = (blank || !pix_valid) ? '0 : paint_f(on_px, fg_r, bg_r);

  AST_VALID_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(load_ev)); // R9
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start) |=> pix_valid); // R9
  AST_RESTART_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (rgbi == '0)); // R9
endmodule

// File: rtl/char_cell_serializer.sv
module char_cell_serializer #(
  parameter int NCOLS = 80,
  parameter int ROW_W = 4,
  localparam int COL_W = (NCOLS > 1) ? $clog2(NCOLS) : 1,
  localparam int GADDR_W = ccs_pkg::FONT_W + ccs_pkg::CHAR_W + ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic [ROW_W-1:0]   row,
  input  logic               font_mode,
  input  logic [3:0]         fixed_bg,
  input  logic               gfx,
  input  logic               ext9,
  input  logic               blank,
  output logic [COL_W-1:0]   dram_addr,
  input  logic [15:0]        dram_data,
  output logic [GADDR_W-1:0] glyph_addr,
  input  logic [7:0]         glyph_data,
  input  logic               glyph_ninth,
  output logic [3:0]         rgbi,
  output logic               pix_valid
);
  import ccs_pkg::*;

  logic  cap_code, cap_glyph, load_ev, hold_full;
  cell_t hold;

  ccs_timing #(.NCOLS(NCOLS)) i_timing (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .col(dram_addr),
    .cap_code(cap_code), .cap_glyph(cap_glyph), .load_ev(load_ev));

  ccs_fetch #(.ROW_W(ROW_W)) i_fetch (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .cap_code(cap_code),
    .cap_glyph(cap_glyph), .load_ev(load_ev), .dram_data(dram_data),
    .font_mode(font_mode), .fixed_bg(fixed_bg), .row(row),
    .glyph_addr(glyph_addr), .glyph_data(glyph_data),
    .glyph_ninth(glyph_ninth), .hold(hold), .hold_full(hold_full));

  ccs_shifter i_shifter (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .load_ev(load_ev),
    .hold(hold), .ext9(ext9), .gfx(gfx), .blank(blank), .rgbi(rgbi),
    .pix_valid(pix_valid));

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (rgbi == '0)); // R8
endmodule

// File: tb/test_char_cell_serializer.sv
module test_char_cell_serializer;
  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [3:0]  row = '0;
  logic        font_mode = 1'b0;
  logic [3:0]  fixed_bg = 4'hA;
  logic        gfx = 1'b0;
  logic        ext9 = 1'b0;
  logic        blank = 1'b0;
  logic [3:0]  dram_addr;
  logic [15:0] dram_data;
  logic [15:0] glyph_addr;
  logic [7:0]  glyph_data;
  logic        glyph_ninth;
  logic [3:0]  rgbi;
  logic        pix_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cur_line = 0;

  always #4 clk = ~clk;

  char_cell_serializer #(.NCOLS(NC), .ROW_W(4)) i_char_cell_serializer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .row(row),
    .font_mode(font_mode), .fixed_bg(fixed_bg), .gfx(gfx), .ext9(ext9),
    .blank(blank), .dram_addr(dram_addr), .dram_data(dram_data),
    .glyph_addr(glyph_addr), .glyph_data(glyph_data),
    .glyph_ninth(glyph_ninth), .rgbi(rgbi), .pix_valid(pix_valid));

  function automatic logic [7:0] char_of(int ln, int c);
    return 8'((ln * 16 + c) & 255);
  endfunction
  function automatic logic [7:0] attr_of(int ln, int c);
    return 8'((ln * 16 + c) * 53 + 17 + ln);
  endfunction
  function automatic logic [7:0] gly_of(logic [15:0] a);
    return 8'(a * 29) ^ 8'(a >> 3) ^ 8'h5A;
  endfunction
  function automatic logic nin_of(logic [15:0] a);
    return ^(a ^ 16'h0133);
  endfunction

  // external memories: one-cycle synchronous reads
  always @(posedge clk) begin
    dram_data   <= {attr_of(cur_line, int'(dram_addr)), char_of(cur_line, int'(dram_addr))};
    glyph_data  <= gly_of(glyph_addr);
    glyph_ninth <= nin_of(glyph_addr);
  end

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h line=%0d", req, act, exp, cur_line);
    end
  endtask

  task automatic run_line(int ln, logic e, logic g, logic fm);
    logic [7:0]  ch, at, gl;
    logic [3:0]  fnt, fg, bg, expc;
    logic [15:0] ga;
    logic        px;
    string       tag;
    @(negedge clk);
    cur_line = ln;
    row = 4'((ln * 5 + 3) & 15);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    // idle window before the first cell (R9)
    for (int k = 0; k < 9; k++) begin
      if (k == 0 || k == 8) begin
        check("R9 idle rgbi", {1'b0, rgbi}, 5'd0);
        check("R9 idle valid", {4'd0, pix_valid}, 5'd0);
      end
      @(negedge clk);
    end
    for (int n = 0; n < NC; n++) begin
      ch  = char_of(ln, n);
      at  = attr_of(ln, n);
      fnt = fm ? at[3:0] : 4'd0;
      ga  = {fnt, ch, row};
      gl  = gly_of(ga);
      fg  = at[7:4];
      bg  = fm ? fixed_bg : at[3:0];
      for (int j = 0; j < 9; j++) begin
        blank = (n == 3) && (ln % 2 == 1);
        #1;
        if (j < 8) begin
          px = gl[7-j];
          tag = fm ? "R1 R2 R7 glyph pixel" : "R1 R2 R6 glyph pixel";
        end else if (e) begin
          px = nin_of(ga);
          tag = "R5 ninth from store";
        end else if (g) begin
          px = gl[0];
          tag = "R4 ninth repeats bit0";
        end else begin
          px = 1'b0;
          tag = "R3 ninth blank";
        end
        expc = blank ? 4'd0 : (px ? fg : bg);
        if (blank) tag = "R8 blanked";
        check(tag, {pix_valid, rgbi}, {1'b1, expc});
        @(negedge clk);
      end
    end
    blank = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rgbi", {1'b0, rgbi}, 5'd0);
    check("R9 reset valid", {4'd0, pix_valid}, 5'd0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      ext9      = cfg[2];
      gfx       = cfg[1];
      font_mode = cfg[0];
      fixed_bg  = 4'(cfg * 3 + 2);
      for (int ln = 0; ln < 16; ln++) run_line(ln, cfg[2], cfg[1], cfg[0]);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule